// File: doc/BRIEF.md
# Half-Step Multi-Modulus Clock Divider

This block divides an input clock by a programmable ratio that moves in steps of half an input cycle, so that a fractional-N loop sees half the quantization step of an integer divider. It is clocked by `clk`, which runs at twice the input rate: one `clk` cycle is one half-cycle (a "tick") of the input. The division word `ratio_i` gives the output period directly in ticks. A word N therefore divides the input by N/2.

The ratio is split into three parts. A phase-switching prescaler nominally divides by two input cycles. It steps its output phase to the leading quadrature neighbour up to three times per output period, and each step removes one tick. A ripple chain of divide-by-2/3 cells follows the prescaler. It is event-enabled, and its modulus feedback runs from the top of the chain down. Range-extension logic picks how many of these cells take part. The output period is then 4·D − k ticks, where D is the chain ratio and k is the switch count. The word may change every output period, as a delta-sigma modulator drives it. The switch count and the chain length are captured when the output falls. The 2/3 control bits are captured when the output rises.

The prescaler has two state machines, each with four Gray-coded states PH_0 → PH_90 → PH_180 → PH_270. One is the free-running quadrature generator, which advances every tick. The other is the selected phase, which on a switch moves only backwards (lead transition). Each 2/3 cell has three states. An input event takes ST_FIRST to ST_SECOND. From ST_SECOND an event goes to ST_EXTRA when swallowing and to ST_FIRST otherwise. ST_EXTRA goes to ST_FIRST on the next event. An inactive cell is forced to ST_FIRST. The output machine has two states. It goes from OUT_LOW to OUT_HIGH on the top cell's first event, and from OUT_HIGH to OUT_LOW when the top cell wraps.

Top module: `hmd_divider`

## Requirements
- R1: With default parameters, a word N in 29..1020 makes the span between consecutive falling edges of `div_o` exactly N `clk` cycles.
- R2: A word below 29 is treated as 29 and a word above 1020 as 1020. `clamp_o` is 1 for an output period whose word was clamped and 0 otherwise. It changes only at a falling edge of `div_o`.
- R3: The period that starts at a falling edge uses the word present at that edge for its switch count and its chain length. It uses the word present at the following rising edge for its 2/3 control bits. A word changed after the rising edge takes effect only in the next period.
- R4: The k = (−N mod 4) half-cycle removals all happen before the rise. `div_o` stays low for 2^(L+1) − k cycles, where L is the index of the most significant set bit of D = (N+k)/4. The selected phase only ever moves to its leading neighbour, and prescaler events are at least 3 cycles apart.
- R5: `mod_o[i]` is the modulus feedback that cell i gives to cell i−1. A cell swallows an extra event only when its control bit (bit i of D) and its incoming feedback are both 1. All `mod_o` bits are 0 in the cycle after a period starts.
- R6: Only cells 0..L−1 are active. `mod_o` bits L and above stay 0 throughout the period.
- R7: During reset and directly after it, `div_o`, `clamp_o` and `mod_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock, twice the input frequency |
| rst_n | input | 1 | Active-low asynchronous reset |
| ratio_i | input | 10 | Output period in ticks (half input cycles) |
| div_o | output | 1 | Divided clock; a period starts at its falling edge |
| clamp_o | output | 1 | Current period's word was outside the range |
| mod_o | output | 7 | Per-stage modulus feedback of the 2/3 chain |

## Verification
`div_o`, `clamp_o` and `mod_o` all change on the rising edge of `clk` where the top cell wraps or steps. The bench therefore samples only on falling edges of `clk` and counts the falling edges between output transitions. The period length is checked at the falling-edge sample where `div_o` is first seen low. The low-phase length is checked at the sample where it is first seen high. The clamp flag and the cleared feedback are checked at the same falling-edge sample, since they are registered in that same clock. A new word is applied only just after a rise, so the current period's expected values are already fixed and the new word is due at the next fall.

// File: rtl/hmd_pkg.sv
package hmd_pkg;

    typedef enum logic [1:0] {
        PH_0   = 2'b00,
        PH_90  = 2'b01,
        PH_180 = 2'b11,
        PH_270 = 2'b10
    } phase_e;

    typedef enum logic [1:0] {
        ST_FIRST  = 2'b00,
        ST_SECOND = 2'b01,
        ST_EXTRA  = 2'b10
    } cell_e;

    typedef enum logic {
        OUT_LOW  = 1'b0,
        OUT_HIGH = 1'b1
    } out_e;

    // quadrature generator advance, one tick
    function automatic phase_e phase_after(input phase_e p);
        phase_e r;
        unique case (p)
            PH_0:    r = PH_90;
            PH_90:   r = PH_180;
            PH_180:  r = PH_270;
            default: r = PH_0;
        endcase
        return r;
    endfunction

    // leading neighbour: the only glitch-free switch target
    function automatic phase_e phase_lead(input phase_e p);
        phase_e r;
        unique case (p)
            PH_0:    r = PH_270;
            PH_90:   r = PH_0;
            PH_180:  r = PH_90;
            default: r = PH_180;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/hmd_phase_cell.sv
module hmd_phase_cell
    import hmd_pkg::*;
#(
    parameter int CW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [CW-1:0] swcnt_i,
    output logic          ev_o
);

    phase_e        quad_q;
    phase_e        sel_q;
    phase_e        sel_nx;
    logic [CW-1:0] rem_q;
    logic [CW-1:0] rem_nx;
    logic          do_sw;

    // next-state logic
    always_comb begin
        do_sw  = ev_o && (rem_q != '0);
        sel_nx = do_sw ? phase_lead(sel_q) : sel_q;
        if (load_i) begin
            rem_nx = swcnt_i;
        end else if (do_sw) begin
            rem_nx = rem_q - 1'b1;
        end else begin
            rem_nx = rem_q;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            quad_q <= PH_0;
            sel_q  <= PH_0;
            rem_q  <= '0;
        end else begin
            quad_q <= phase_after(quad_q);
            sel_q  <= sel_nx;
            rem_q  <= rem_nx;
        end
    end

    // output: one event per coincidence of generator and selected phase
    always_comb begin
        ev_o = (quad_q == sel_q);
    end

    p_lead_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_q != $past(sel_q)) |-> (sel_q == phase_lead($past(sel_q))));

    p_event_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ev_o |=> !ev_o ##1 !ev_o);

    p_switches_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |-> (rem_q == '0));

endmodule

// File: rtl/hmd_cell23.sv
module hmd_cell23
    import hmd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic active_i,
    input  logic ev_i,
    input  logic p_i,
    input  logic mod_in_i,
    output logic ev_o,
    output logic mod_o,
    output logic mid_o
);

    cell_e state_q;
    cell_e state_nx;
    logic  swallow;
    logic  last;

    always_comb begin
        swallow = p_i && mod_in_i;
        last    = (state_q == ST_EXTRA) || ((state_q == ST_SECOND) && !swallow);
    end

    // next-state logic
    always_comb begin
        state_nx = state_q;
        if (!active_i) begin
            state_nx = ST_FIRST;
        end else if (ev_i) begin
            unique case (state_q)
                ST_FIRST:  state_nx = ST_SECOND;
                ST_SECOND: state_nx = swallow ? ST_EXTRA : ST_FIRST;
                ST_EXTRA:  state_nx = ST_FIRST;
                default:   state_nx = ST_FIRST;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_FIRST;
        end else begin
            state_q <= state_nx;
        end
    end

    // outputs
    always_comb begin
        ev_o  = active_i && ev_i && last;
        mod_o = active_i && mod_in_i && last;
        mid_o = active_i && ev_i && (state_q == ST_FIRST);
    end

    p_swallow_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_EXTRA) && ($past(state_q) == ST_SECOND)) |-> $past(p_i && mod_in_i));

    p_idle_cell_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !active_i |=> (state_q == ST_FIRST));

endmodule

// File: rtl/hmd_divider.sv
module hmd_divider
    import hmd_pkg::*;
#(
    parameter int RW      = 10,
    parameter int NSTG    = 7,
    parameter int MIN_STG = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [RW-1:0]   ratio_i,
    output logic            div_o,
    output logic            clamp_o,
    output logic [NSTG-1:0] mod_o
);

    localparam int LW       = $clog2(NSTG + 1);
    localparam int DW       = NSTG + 1;
    localparam int TICK_MIN = 4 * (2 ** MIN_STG) - 3;
    localparam int TICK_MAX = 4 * (2 ** (NSTG + 1) - 1);

    typedef struct packed {
        logic [1:0]      swcnt;
        logic [LW-1:0]   top;
        logic [NSTG-1:0] bits;
        logic            clamp;
    } ctrl_t;

    function automatic ctrl_t decode(input logic [RW-1:0] w);
        ctrl_t          c;
        int             n;
        int             k;
        logic [DW-1:0]  dv;
        n       = int'(w);
        c.clamp = 1'b0;
        if (n < TICK_MIN) begin
            n       = TICK_MIN;
            c.clamp = 1'b1;
        end else if (n > TICK_MAX) begin
            n       = TICK_MAX;
            c.clamp = 1'b1;
        end
        k       = (4 - (n % 4)) % 4;
        dv      = DW'((n + k) / 4);
        c.swcnt = 2'(k);
        c.top   = '0;
        for (int j = 0; j < DW; j++) begin
            if (dv[j]) c.top = LW'(j);
        end
        c.bits = dv[NSTG-1:0];
        for (int j = 0; j < NSTG; j++) begin
            if (LW'(j) == c.top) c.bits[j] = 1'b0;
        end
        return c;
    endfunction

    ctrl_t           ctl_now;
    logic [LW-1:0]   top_q;
    logic [LW-1:0]   top_idx;
    logic [NSTG-1:0] bits_q;
    logic            clamp_q;
    logic            ph_ev;
    logic [NSTG-1:0] ev_chain;
    logic [NSTG-1:0] mid_chain;
    logic [NSTG-1:0] mod_chain;
    logic [NSTG-1:0] mod_in;
    logic [NSTG-1:0] ev_in;
    logic [NSTG-1:0] active;
    logic            bound_ev;
    logic            rise_ev;
    out_e            out_q;
    out_e            out_nx;

    always_comb begin
        ctl_now  = decode(ratio_i);
        top_idx  = top_q - 1'b1;
        bound_ev = ev_chain[top_idx];
        rise_ev  = mid_chain[top_idx];
    end

    hmd_phase_cell #(.CW(2)) u_phase (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (bound_ev),
        .swcnt_i (ctl_now.swcnt),
        .ev_o    (ph_ev)
    );

    for (genvar g = 0; g < NSTG; g++) begin : g_chain
        if (g == 0) begin : g_first
            assign ev_in[g] = ph_ev;
        end else begin : g_rest
            assign ev_in[g] = ev_chain[g-1];
        end
        if (g == NSTG - 1) begin : g_end
            assign mod_in[g] = 1'b1;
        end else begin : g_mid
            assign mod_in[g] = (top_idx == LW'(g)) ? 1'b1 : mod_chain[g+1];
        end
        assign active[g] = (LW'(g) < top_q);

        hmd_cell23 u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .active_i (active[g]),
            .ev_i     (ev_in[g]),
            .p_i      (bits_q[g]),
            .mod_in_i (mod_in[g]),
            .ev_o     (ev_chain[g]),
            .mod_o    (mod_chain[g]),
            .mid_o    (mid_chain[g])
        );
    end

    // control capture: extent and switch count at fall, 2/3 bits at rise
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            top_q   <= LW'(MIN_STG);
            clamp_q <= 1'b0;
            bits_q  <= '0;
        end else begin
            if (bound_ev) begin
                top_q   <= ctl_now.top;
                clamp_q <= ctl_now.clamp;
            end
            if (rise_ev) begin
                bits_q <= ctl_now.bits;
            end
        end
    end

    // output state machine: next state
    always_comb begin
        out_nx = out_q;
        unique case (out_q)
            OUT_LOW:  if (rise_ev)  out_nx = OUT_HIGH;
            OUT_HIGH: if (bound_ev) out_nx = OUT_LOW;
            default:  out_nx = OUT_LOW;
        endcase
    end

    // output state machine: state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= OUT_LOW;
        end else begin
            out_q <= out_nx;
        end
    end

    // outputs
    always_comb begin
        div_o   = (out_q == OUT_HIGH);
        clamp_o = clamp_q;
        mod_o   = mod_chain;
    end

    p_mod_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        bound_ev |=> (mod_o == '0));

    p_clamp_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !bound_ev |=> $stable(clamp_o));

    p_rise_from_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rise_ev |-> !div_o);

    p_upper_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((mod_o >> top_q) == '0));

endmodule

// File: tb/hmd_divider_tb.sv
module hmd_divider_tb;

    localparam int CLK_PERIOD = 10;
    localparam int N_MIN      = 29;
    localparam int N_MAX      = 1020;
    localparam int PERIODS    = 70;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [9:0] ratio_i;
    logic       div_o;
    logic       clamp_o;
    logic [6:0] mod_o;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    hmd_divider u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .ratio_i (ratio_i),
        .div_o   (div_o),
        .clamp_o (clamp_o),
        .mod_o   (mod_o)
    );

    function automatic int eff(input int w);
        if (w < N_MIN) return N_MIN;
        if (w > N_MAX) return N_MAX;
        return w;
    endfunction

    function automatic int top_of(input int n);
        int k;
        int d;
        int t;
        k = (4 - (n % 4)) % 4;
        d = (n + k) / 4;
        t = 0;
        for (int j = 0; j < 9; j++) if (d >= (1 << j)) t = j;
        return t;
    endfunction

    function automatic int low_of(input int n);
        int k;
        k = (4 - (n % 4)) % 4;
        return (1 << (top_of(n) + 1)) - k;
    endfunction

    function automatic int next_word(input int idx);
        case (idx)
            0: return 29;
            1: return 1020;
            2: return 30;
            3: return 31;
            4: return 32;
            5: return 33;
            6: return 20;
            7: return 1023;
            8: return 64;
            9: return 61;
            default: begin
                if (idx % 10 == 0) return int'($urandom_range(28, 0));
                return int'($urandom_range(N_MAX, N_MIN));
            end
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    initial begin
        int unused_seed;
        int t;
        int cur;
        int exp_per;
        int exp_low;
        int exp_top;
        int idx;
        int periods;
        bit measuring;
        bit prev;
        bit hi_bad;
        unused_seed = $urandom(32'd4711);
        ratio_i   = 10'd29;
        rst_n     = 1'b0;
        repeat (4) @(negedge clk);
        // R7: reset state
        check(div_o == 1'b0,   "R7 div_o in reset",   int'(div_o),   0);
        check(clamp_o == 1'b0, "R7 clamp_o in reset", int'(clamp_o), 0);
        check(mod_o == '0,     "R7 mod_o in reset",   int'(mod_o),   0);
        rst_n = 1'b1;
        @(negedge clk);
        check(div_o == 1'b0, "R7 div_o after reset", int'(div_o), 0);
        t = 1; idx = 0; periods = 0; measuring = 1'b0; prev = div_o; hi_bad = 1'b0;
        cur = 29; exp_per = 0; exp_low = 0; exp_top = 0;
        while (periods < PERIODS) begin
            @(negedge clk);
            t++;
            if (measuring && ((mod_o >> exp_top) != '0)) hi_bad = 1'b1;
            if (prev && !div_o) begin
                if (measuring) begin
                    // R1 R3: period equals word captured for it
                    check(t == exp_per, "R1 R3 period", t, exp_per);
                    check(!hi_bad, "R6 upper feedback idle", int'(hi_bad), 0);
                end
                cur     = int'(ratio_i);
                exp_per = eff(cur);
                exp_low = low_of(exp_per);
                exp_top = top_of(exp_per);
                check(clamp_o == ((cur < N_MIN) || (cur > N_MAX)), "R2 clamp flag",
                      int'(clamp_o), int'((cur < N_MIN) || (cur > N_MAX)));
                check(mod_o == '0, "R5 feedback cleared at start", int'(mod_o), 0);
                hi_bad    = 1'b0;
                measuring = 1'b1;
                t         = 0;
                periods++;
            end else if (!prev && div_o && measuring) begin
                check(t == exp_low, "R4 low phase length", t, exp_low);
                // R3: new word applied after the rise only
                ratio_i = 10'(next_word(idx));
                idx++;
            end
            prev = div_o;
        end
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule